// File: doc/BRIEF.md
# Constant On-Time Buck Switch Timing Controller

This block decides when the high-side and low-side switches of a synchronous buck stage are requested on. It has no oscillator. A high-side pulse of programmed length is launched only when a synchronous feedback flag reports the output at or below its reference. Every high-side pulse is followed by a low-side interval of at least a programmed minimum off-time, and that interval can be doubled on request. Comparator results, the on-time count and the off-time count all come from outside as plain synchronous signals. The two request outputs feed a separate dead-time stage.

Two protective paths act on the timing. While a valley overcurrent flag is set, no high-side pulse may begin and the low side stays on. When the negative-current flag is seen while the low side is on in the off interval, the low side is released. The block then waits a fixed retry interval and turns the low side on briefly to sense the current again. This repeats for as long as the flag is still set at the end of each sense window. When enable rises, switching opens with a low-side interval. When enable falls, both requests drop and the timer is cleared.

All counts are in clock cycles. An on-time or off-time count of zero is treated as one. Both counts are sampled when the interval that uses them begins, so a change takes effect on the next interval of that kind.

Top module: `cot_pwm_ctrl`

## Requirements
- R1: If `en` is low at a clock edge, `hs_req` and `ls_req` are both low after that edge. The interval timer restarts from zero, so the next enable begins a fresh interval.
- R2: At the first edge with `en` high after the block was disabled, `ls_req` goes high and `hs_req` stays low. This low-side interval lasts the full minimum off-time of R4.
- R3: A high-side pulse starts only at the edge that ends a completed off interval, and only if `fb_low` is 1 and `valley_oc` is 0 at that edge. `hs_req` then stays high for exactly max(`ton_cnt`,1) cycles, using the value of `ton_cnt` sampled at that edge.
- R4: When a high-side pulse ends, `ls_req` is high for exactly L cycles before any new high-side pulse. L is max(`toff_cnt`,1) when `dbl_off` is 0 and 2·max(`toff_cnt`,1) when `dbl_off` is 1. Both inputs are sampled at the edge that begins the off interval. If `fb_low` stays high, the next high-side pulse follows directly.
- R5: `fb_low` has no effect while `hs_req` is high or before the off interval has run its full length. A flag that drops before the off interval ends launches no pulse, and `ls_req` stays high.
- R6: While `valley_oc` is 1, `hs_req` does not rise and `ls_req` stays high. If `fb_low` is 1 when `valley_oc` clears, `hs_req` rises at the next edge.
- R7: If `neg_cur` is 1 at an edge while the block is in its off or waiting state, `ls_req` is low after that edge.
- R8: After a negative-current release, both requests stay low for WAIT_CYC cycles, then `ls_req` is high for SENSE_CYC cycles. If `neg_cur` is 1 at the last sense cycle, this wait-and-sense sequence repeats. Otherwise `ls_req` stays high and the block waits for feedback as in R3.
- R9: `hs_req` and `ls_req` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables switching when high |
| fb_low | input | 1 | Output at or below reference (synchronous flag) |
| ton_cnt | input | CNT_W | High-side on-time in cycles (0 treated as 1) |
| toff_cnt | input | CNT_W | Minimum off-time in cycles (0 treated as 1) |
| dbl_off | input | 1 | Doubles the minimum off-time |
| valley_oc | input | 1 | Valley overcurrent flag, blocks high-side start |
| neg_cur | input | 1 | Negative inductor current flag |
| hs_req | output | 1 | High-side switch request |
| ls_req | output | 1 | Low-side switch request |

## Verification
Every output is a direct decode of one state register. An input applied before an edge therefore shows at the outputs right after that edge: the release on disable, the first low side after enable, the high-side start once the off interval is over, the low-side release on negative current, and the high-side start when the overcurrent flag clears. The bench drives inputs on falling edges and samples one falling edge later to check these one-cycle responses. Interval lengths are checked by counting, at successive falling edges, the run of samples for which a request holds its level. These counts are compared with the on-time, off-time, retry and sense lengths computed from the programmed values. A sweep over every small on-time, off-time and doubling setting lets two full periods pass after each change before it measures, so that the sampling at pulse start is respected.

// File: rtl/cot_pkg.sv
package cot_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_ON     = 3'd1,
    ST_OFF    = 3'd2,
    ST_NWAIT  = 3'd3,
    ST_NSENSE = 3'd4
  } cot_state_e;
endpackage

// File: rtl/cot_len_sel.sv
module cot_len_sel #(
  parameter int CNT_W = 8,
  parameter int TW    = 9
) (
  input  logic [CNT_W-1:0] ton_cnt,
  input  logic [CNT_W-1:0] toff_cnt,
  input  logic             dbl_off,
  output logic [TW-1:0]    on_ld,
  output logic [TW-1:0]    off_ld
);
  logic [TW-1:0] off_base;
  logic [TW-1:0] off_len;

  always_comb begin
    on_ld    = (ton_cnt == '0) ? '0 : (TW'(ton_cnt) - TW'(1));
    off_base = (toff_cnt == '0) ? TW'(1) : TW'(toff_cnt);
    off_len  = dbl_off ? (off_base << 1) : off_base;
    off_ld   = off_len - TW'(1);
  end
endmodule

// File: rtl/cot_timer.sv
module cot_timer #(
  parameter int TW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [TW-1:0] load_val,
  output logic          zero
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - TW'(1);
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/cot_fsm.sv
module cot_fsm
  import cot_pkg::*;
#(
  parameter int TW        = 9,
  parameter int WAIT_CYC  = 250,
  parameter int SENSE_CYC = 38
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fb_low,
  input  logic          valley_oc,
  input  logic          neg_cur,
  input  logic          t_zero,
  input  logic [TW-1:0] on_ld,
  input  logic [TW-1:0] off_ld,
  output logic          t_load,
  output logic [TW-1:0] t_val,
  output logic          hs_req,
  output logic          ls_req
);
  localparam logic [TW-1:0] WAIT_LD  = TW'(WAIT_CYC - 1);
  localparam logic [TW-1:0] SENSE_LD = TW'(SENSE_CYC - 1);

  cot_state_e st, nxt;

  always_comb begin
    nxt    = st;
    t_load = 1'b0;
    t_val  = '0;
    case (st)
      ST_IDLE: begin
        nxt = ST_OFF; t_load = 1'b1; t_val = off_ld;
      end
      ST_ON: if (t_zero) begin
        nxt = ST_OFF; t_load = 1'b1; t_val = off_ld;
      end
      ST_OFF: begin
        if (neg_cur) begin
          nxt = ST_NWAIT; t_load = 1'b1; t_val = WAIT_LD;
        end else if (t_zero && fb_low && !valley_oc) begin
          nxt = ST_ON; t_load = 1'b1; t_val = on_ld;
        end
      end
      ST_NWAIT: if (t_zero) begin
        nxt = ST_NSENSE; t_load = 1'b1; t_val = SENSE_LD;
      end
      ST_NSENSE: if (t_zero) begin
        if (neg_cur) begin
          nxt = ST_NWAIT; t_load = 1'b1; t_val = WAIT_LD;
        end else begin
          nxt = ST_OFF; t_load = 1'b1; t_val = '0;
        end
      end
      default: nxt = ST_IDLE;
    endcase
    if (!en) begin
      nxt    = ST_IDLE;
      t_load = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= ST_IDLE;
    else        st <= nxt;
  end

  assign hs_req = (st == ST_ON);
  assign ls_req = (st == ST_OFF) || (st == ST_NSENSE);

  p_no_overlap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs_req && ls_req));
  p_disable_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!hs_req && !ls_req));
  p_first_ls_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE && en) |=> (ls_req && !hs_req));
  p_hs_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs_req) |-> $past(fb_low && t_zero && !valley_oc));
  p_fb_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && !t_zero) |=> !hs_req);
  p_oc_block_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hs_req && valley_oc) |=> !hs_req);
  p_neg_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OFF && neg_cur && en) |=> !ls_req);
endmodule

// File: rtl/cot_pwm_ctrl.sv
module cot_pwm_ctrl #(
  parameter int CNT_W     = 8,
  parameter int WAIT_CYC  = 250,
  parameter int SENSE_CYC = 38
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic             fb_low,
  input  logic [CNT_W-1:0] ton_cnt,
  input  logic [CNT_W-1:0] toff_cnt,
  input  logic             dbl_off,
  input  logic             valley_oc,
  input  logic             neg_cur,
  output logic             hs_req,
  output logic             ls_req
);
  localparam int RMAX = (WAIT_CYC > SENSE_CYC) ? WAIT_CYC : SENSE_CYC;
  localparam int RW   = $clog2(RMAX + 1);
  localparam int TW   = (RW > CNT_W + 1) ? RW : CNT_W + 1;

  logic [TW-1:0] on_ld, off_ld, t_val;
  logic          t_load, t_zero;

  cot_len_sel #(.CNT_W(CNT_W), .TW(TW)) len_i (
    .ton_cnt(ton_cnt), .toff_cnt(toff_cnt), .dbl_off(dbl_off),
    .on_ld(on_ld), .off_ld(off_ld)
  );

  cot_timer #(.TW(TW)) tmr_i (
    .clk(clk), .rst_n(rst_n), .clr(!en), .load(t_load),
    .load_val(t_val), .zero(t_zero)
  );

  cot_fsm #(.TW(TW), .WAIT_CYC(WAIT_CYC), .SENSE_CYC(SENSE_CYC)) fsm_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_low(fb_low),
    .valley_oc(valley_oc), .neg_cur(neg_cur), .t_zero(t_zero),
    .on_ld(on_ld), .off_ld(off_ld), .t_load(t_load), .t_val(t_val),
    .hs_req(hs_req), .ls_req(ls_req)
  );
endmodule

// File: tb/cot_pwm_ctrl_tb_top.sv
module cot_pwm_ctrl_tb_top;
  localparam int CW = 4;
  localparam int WC = 12;
  localparam int SC = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, fb_low = 1'b0, dbl_off = 1'b0, valley_oc = 1'b0, neg_cur = 1'b0;
  logic [CW-1:0] ton_cnt = 4'd3, toff_cnt = 4'd2;
  logic hs_req, ls_req;
  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cot_pwm_ctrl #(.CNT_W(CW), .WAIT_CYC(WC), .SENSE_CYC(SC)) dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .fb_low(fb_low), .ton_cnt(ton_cnt),
    .toff_cnt(toff_cnt), .dbl_off(dbl_off), .valley_oc(valley_oc),
    .neg_cur(neg_cur), .hs_req(hs_req), .ls_req(ls_req)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_len(input bit use_hs, input bit lvl, output int n);
    n = 0;
    while (((use_hs ? hs_req : ls_req) == lvl) && n < 2000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic wait_rise();
    int g = 0;
    while (hs_req && g < 2000) begin g++; @(negedge clk); end
    while (!hs_req && g < 4000) begin g++; @(negedge clk); end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int n, exp_on, exp_off;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset hs", hs_req, 0);
    chk("reset ls", ls_req, 0);

    // R2: first action after enable is low side
    en = 1'b1;
    @(negedge clk);
    chk("R2 ls after enable", ls_req, 1);
    chk("R2 hs after enable", hs_req, 0);
    repeat (5) @(negedge clk);
    chk("R5 no fb -> ls held", ls_req, 1);

    // R3/R4 sweep of on-time, off-time, doubling
    fb_low = 1'b1;
    for (int t = 0; t < 5; t++) begin
      for (int f = 0; f < 4; f++) begin
        for (int d = 0; d < 2; d++) begin
          ton_cnt = CW'(t); toff_cnt = CW'(f); dbl_off = d[0];
          wait_rise(); wait_rise();
          exp_on  = (t == 0) ? 1 : t;
          exp_off = ((f == 0) ? 1 : f) * (d ? 2 : 1);
          run_len(1'b1, 1'b1, n);
          chk("R3 on length", n, exp_on);
          chk("R9 ls after on", ls_req, 1);
          run_len(1'b0, 1'b1, n);
          chk("R4 off length", n, exp_off);
          chk("R4 hs restarts", hs_req, 1);
        end
      end
    end

    // R5: fb ignored during on and off; ton change takes next pulse
    fb_low = 1'b0; ton_cnt = 4'd3; toff_cnt = 4'd4; dbl_off = 1'b0;
    repeat (20) @(negedge clk);
    fb_low = 1'b1;
    for (int i = 1; i <= 20; i++) begin
      @(negedge clk);
      chk("R5 hs pattern", hs_req, (i >= 1 && i <= 3) ? 1 : 0);
      chk("R5 ls pattern", ls_req, (i >= 4) ? 1 : 0);
      fb_low = (i == 2 || i == 5);
      if (i == 2) ton_cnt = 4'd6;
    end
    fb_low = 1'b1;
    @(negedge clk);
    fb_low = 1'b0;
    run_len(1'b1, 1'b1, n);
    chk("R3 new ton applied", n, 6);
    repeat (10) @(negedge clk);

    // R6: valley overcurrent blocks high side
    valley_oc = 1'b1;
    repeat (3) @(negedge clk);
    fb_low = 1'b1;
    for (int i = 0; i < 15; i++) begin
      @(negedge clk);
      chk("R6 hs blocked", hs_req, 0);
      chk("R6 ls held", ls_req, 1);
    end
    valley_oc = 1'b0;
    @(negedge clk);
    chk("R6 hs after clear", hs_req, 1);
    fb_low = 1'b0;
    repeat (20) @(negedge clk);

    // R7/R8: negative current retry
    neg_cur = 1'b1;
    @(negedge clk);
    chk("R7 ls released", ls_req, 0);
    run_len(1'b0, 1'b0, n);
    chk("R8 wait length", n, WC);
    run_len(1'b0, 1'b1, n);
    chk("R8 sense length", n, SC);
    run_len(1'b0, 1'b0, n);
    chk("R8 repeat wait", n, WC);
    neg_cur = 1'b0;
    run_len(1'b0, 1'b1, n);
    chk("R8 ls stays on after recovery", n, 2000);
    chk("R8 no hs without fb", hs_req, 0);

    // R1: disable mid-pulse, then R2 fresh start
    fb_low = 1'b1; ton_cnt = 4'd5;
    wait_rise();
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    chk("R1 hs low", hs_req, 0);
    chk("R1 ls low", ls_req, 0);
    repeat (4) @(negedge clk);
    chk("R1 held low", hs_req + ls_req, 0);
    toff_cnt = 4'd3; dbl_off = 1'b1;
    en = 1'b1;
    @(negedge clk);
    chk("R2 ls first", ls_req, 1);
    chk("R2 hs not first", hs_req, 0);
    run_len(1'b0, 1'b1, n);
    chk("R1 R2 full first off", n, 6);
    chk("R3 hs follows", hs_req, 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule